// File: doc/BRIEF.md
# Multibit-Trie Longest Prefix Lookup

This block resolves a 32-bit IPv4 destination address to a next-hop identifier. It walks a trie kept in an internal node memory. At every step it takes the next four address bits, most significant first, and uses them to pick one of sixteen slots in the current node. Each slot carries two fields: a route field that names a next hop, and a child field that names the node one level deeper. Whenever a visited slot has a non-zero route field, that route becomes the best candidate. The walk ends when the child field is zero or when all eight nibbles have been used. The last candidate is the longest matching prefix.

Only one lookup runs at a time. While a lookup is in progress, `busy` is high, and a requester holds its request until `busy` falls. The trie contents are written through a simple load port before lookups start. A prefix whose length is not a multiple of four is stored by repeating its route in every slot its last partial nibble covers.

Top module: `trie_lpm`

## Requirements
- R1: After reset, `busy` and `res_valid` are low.
- R2: The lookup takes address nibbles from bits 31:28 down to bits 3:0. At level L (0 = root), the nibble selects slot L's nibble value within the current node. The root is node 0.
- R3: A slot with a non-zero route field replaces the best candidate. The result is the route of the deepest visited slot whose route field is non-zero. Example: a lookup of 0x13FE2233 in the four-node sample table returns hop 4.
- R4: The walk stops after a slot whose child field is zero. If no visited slot had a non-zero route, the result has `res_found` = 0 and `res_hop` = 0. Otherwise `res_found` = 1.
- R5: At most 8 levels are visited. A non-zero child field at level 8 is not followed.
- R6: If a request is accepted on clock edge E and the walk visits n levels, `res_valid` is high for exactly one cycle, starting at edge E+n. `busy` is high from E up to E+n and falls at E+n.
- R7: A request is accepted only on an edge where `busy` is low. A request presented while `busy` is high leaves the lookup in progress unaffected. If the request is held, it is accepted on the first edge after `busy` falls.
- R8: On an edge where `ld_en` is high, the slot at index `ld_addr` = {node[5:0], nibble[3:0]} is written with `ld_data` = {route[7:0], child[5:0]}. A later write to the same slot replaces the earlier value. A zero in either field means null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Destination address to resolve |
| busy | output | 1 | Lookup in progress; requests are not taken |
| ld_en | input | 1 | Write one trie slot |
| ld_addr | input | 10 | Slot index {node, nibble} |
| ld_data | input | 14 | Slot contents {route, child} |
| res_valid | output | 1 | One-cycle result strobe |
| res_hop | output | 8 | Next hop of the longest match, 0 when none |
| res_found | output | 1 | A matching route was found |

## Verification
For every lookup, the bench counts the levels its own reference walk visits. It expects the `res_valid` strobe exactly that many edges after the accepting edge, and checks the hop, the found flag and this arrival count together, sampling 1 ns after each edge. In the held-request case, the second result is expected one edge after the first strobe plus its own level count. The cycle between the two lookups is checked to show `busy` high and no strobe.

// File: rtl/trie_lpm.sv
module trie_lpm #(
  parameter int ADDR_W  = 32,
  parameter int STRIDE  = 4,
  parameter int NODE_AW = 6,
  parameter int HOP_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        busy,
  input  logic                        ld_en,
  input  logic [NODE_AW+STRIDE-1:0]   ld_addr,
  input  logic [HOP_W+NODE_AW-1:0]    ld_data,
  output logic                        res_valid,
  output logic [HOP_W-1:0]            res_hop,
  output logic                        res_found
);
  localparam int LEVELS = ADDR_W / STRIDE;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int SLOT_W = HOP_W + NODE_AW;
  localparam int MEM_AW = NODE_AW + STRIDE;

  logic [SLOT_W-1:0]  mem [1<<MEM_AW];
  logic [ADDR_W-1:0]  addr_sh;
  logic [NODE_AW-1:0] node;
  logic [LVL_W-1:0]   level;
  logic [HOP_W-1:0]   best;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  wire [STRIDE-1:0]  nib     = addr_sh[ADDR_W-1 -: STRIDE];
  wire [SLOT_W-1:0]  slot    = mem[{node, nib}];
  wire [HOP_W-1:0]   s_route = slot[SLOT_W-1 -: HOP_W];
  wire [NODE_AW-1:0] s_child = slot[NODE_AW-1:0];
  wire [HOP_W-1:0]   best_nx = (s_route != '0) ? s_route : best;
  wire               last    = (s_child == '0) || (level == LVL_W'(LEVELS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      addr_sh   <= '0;
      node      <= '0;
      level     <= '0;
      best      <= '0;
      res_valid <= 1'b0;
      res_hop   <= '0;
      res_found <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          addr_sh <= req_addr;
          node    <= '0;
          level   <= '0;
          best    <= '0;
        end
      end else begin
        best    <= best_nx;
        addr_sh <= addr_sh << STRIDE;
        node    <= s_child;
        level   <= level + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_hop   <= best_nx;
          res_found <= (best_nx != '0);
        end
      end
    end
  end
endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk #(
  parameter int LEVELS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic res_valid
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;

  assert_walk_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 8'(LEVELS)));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_end_gives_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);

  assert_start_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_idle_takes_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
endmodule

bind trie_lpm trie_lpm_chk #(.LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .res_valid(res_valid));

// File: tb/sim_trie_lpm.sv
module sim_trie_lpm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [13:0] ld_data = '0;
  logic        busy, res_valid, res_found;
  logic [7:0]  res_hop;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  logic [7:0] tb_route [1024];
  logic [5:0] tb_child [1024];

  trie_lpm u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .res_valid(res_valid), .res_hop(res_hop), .res_found(res_found));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string msg);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic ld(input int nd, input int sl, input int rt, input int ch);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_addr = 10'(nd * 16 + sl);
    ld_data = {8'(rt), 6'(ch)};
    tb_route[nd * 16 + sl] = 8'(rt);
    tb_child[nd * 16 + sl] = 6'(ch);
  endtask

  task automatic ld_done();
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic void walk(input logic [31:0] a, output logic [7:0] hop, output int lv);
    int nd = 0;
    hop = '0;
    lv = 0;
    for (int l = 0; l < 8; l++) begin
      int ix = nd * 16 + int'(a[31 - 4*l -: 4]);
      lv = l + 1;
      if (tb_route[ix] != 0) hop = tb_route[ix];
      if (tb_child[ix] == 0) break;
      nd = int'(tb_child[ix]);
    end
  endfunction

  task automatic lookup(input logic [31:0] a, input string tag);
    logic [7:0] eh;
    int el, n;
    walk(a, eh, el);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (!res_valid && n < 20);
    check(res_valid && res_hop == eh && res_found == (eh != 0) && n == el, tag,
      $sformatf("addr %h actual hop %0d found %0b after %0d, expected hop %0d found %0b after %0d",
        a, res_hop, res_found, n, eh, eh != 0, el));
  endtask

  initial begin
    #1;
    check(!busy && !res_valid, "R1",
      $sformatf("reset actual busy %0b res_valid %0b, expected 0 0", busy, res_valid));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(!busy && !res_valid, "R1",
      $sformatf("after reset actual busy %0b res_valid %0b, expected 0 0", busy, res_valid));

    for (int i = 0; i < 1024; i++) ld(i / 16, i % 16, 0, 0);
    ld(0, 2, 1, 0);
    ld(0, 1, 0, 1);
    ld(1, 3, 2, 2);
    ld(2, 0, 3, 0);
    ld(2, 15, 0, 3);
    ld(3, 14, 4, 0);
    ld(3, 15, 4, 0);
    ld(0, 9, 50, 10);
    for (int k = 0; k < 7; k++) ld(10 + k, 9, (k % 2 == 0) ? 100 + k : 0, 11 + k);
    ld(17, 9, 200, 5);
    ld(5, 9, 99, 0);
    ld_done();

    lookup(32'h13FE2233, "R3");
    lookup(32'h13FF0000, "R3");
    lookup(32'h13F00000, "R3");
    lookup(32'h13012345, "R3");
    lookup(32'h13A00000, "R4");
    lookup(32'h50000000, "R4");
    lookup(32'h10000000, "R4");
    lookup(32'h2ABCDEF0, "R2");

    for (int h = 0; h < 256; h++) lookup({8'(h), 24'h3F_E5A7}, "R2");
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 16; k++) lookup(32'h13000000 | (j << 20) | (k << 16), "R3");
    for (int d = 1; d <= 8; d++) begin
      logic [31:0] a = 32'h99999999;
      if (d < 8) a[31 - 4*d -: 4] = 4'h0;
      lookup(a, (d == 8) ? "R5" : "R6");
    end

    // R7: request held while busy
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h13FE2233;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'h2000_0000;
    repeat (3) @(posedge clk);
    @(posedge clk); #1;
    check(res_valid && res_hop == 8'd4, "R7",
      $sformatf("first actual valid %0b hop %0d, expected 1 4", res_valid, res_hop));
    @(posedge clk); #1;
    check(!res_valid && busy, "R7",
      $sformatf("gap actual valid %0b busy %0b, expected 0 1", res_valid, busy));
    @(negedge clk) req_valid = 1'b0;
    @(posedge clk); #1;
    check(res_valid && res_hop == 8'd1 && !busy, "R7",
      $sformatf("second actual valid %0b hop %0d busy %0b, expected 1 1 0", res_valid, res_hop, busy));

    // R8: overwrite a slot
    ld(0, 2, 7, 0);
    ld_done();
    lookup(32'h2000_0000, "R8");
    ld(0, 5, 33, 0);
    ld_done();
    lookup(32'h5000_0000, "R8");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule